// File: doc/BRIEF.md
# ADC Interrupt Flag Controller

This block keeps the interrupt and DMA-trigger status of a twelve-channel analog-to-digital controller that runs two conversion sequences, A and B. Each channel reports completed conversions, reads of its result register and two kinds of threshold event. Each sequence reports completed conversions, end of the whole sequence and reads of its global data register. From these pulses the block keeps per-channel threshold flags, per-channel and per-sequence overrun status and two sequence flags. It also builds two summary flags, one for threshold events and one for overruns.

Software sees one 32-bit flags word and one enable word on a simple single-cycle bus. Threshold flags and the end-of-sequence flags clear when software writes a 1 to them. The other status bits are read-only copies of state that clears when the data is read. Each sequence has a mode input. With mode 0 its flag follows "new global data present". With mode 1 its flag is latched at the end of the sequence. The four interrupt outputs are the sequence A flag, the sequence B flag, the threshold summary and the overrun summary, each ANDed with its bit in the enable word. The sequence outputs also serve as DMA requests.

Top module: `adc_irq_flags`

## Requirements
- R1: After reset, the flags word (bus_addr 0) and the enable word (bus_addr 1) read 0 and all four interrupt outputs are low.
- R2: Channel n's threshold flag (flags bit n, n = 0..11) is set one cycle after thr_range_evt[n] while enable bit 4+n is 1, or after thr_cross_evt[n] while enable bit 16+n is 1. An event whose kind is not enabled leaves the flag unchanged.
- R3: A write to the flags word with bit n = 1 clears threshold flag n, and bits written as 0 leave it unchanged. An enabled event in the same cycle as the clear wins, and the flag stays 1.
- R4: Flags bit 30 is the OR of the twelve threshold flags. It stays 1 until every threshold flag has been cleared.
- R5: A channel result becomes valid on ch_conv_done[n] and is consumed by ch_data_rd[n]. A conversion that completes while the result is still valid and is not being read sets the channel overrun bit (flags bit 12+n). ch_data_rd[n] clears that bit.
- R6: With seq_mode[s] = 0, the sequence flag (bit 28 for A, bit 29 for B) shows whether global data is present. It is set by seq_conv_done[s], cleared by seq_gdat_rd[s], and a write of 1 to it has no effect.
- R7: With seq_mode[s] = 1, the sequence flag is set by seq_end[s] and holds until a write of 1 to bit 28+s. A seq_end[s] in the same cycle as that write wins. Conversions do not set the flag, and seq_end has no effect while the mode is 0.
- R8: Bit 24+s copies the global overrun of sequence s. It is set by seq_conv_done[s] while global data is present and is not being read in that cycle, and it is cleared by seq_gdat_rd[s].
- R9: Flags bit 31 is the OR of all channel overrun bits and of each sequence overrun bit whose seq_mode is 0. It falls only when every contributing bit is clear.
- R10: irq_seq_a, irq_seq_b, irq_ovr and irq_thr equal flags bits 28, 29, 31 and 30 ANDed with enable bits 0, 1, 2 and 3 respectively.
- R11: Writes to read-only flag bits (12..31 except the sequence flags in mode 1) have no effect. Unused bits read 0, and enable bits 28..31 cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the word chosen by bus_addr |
| bus_addr | input | 1 | 0 selects the flags word, 1 selects the enable word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| ch_conv_done | input | 12 | Per-channel conversion-complete pulse |
| ch_data_rd | input | 12 | Per-channel result-register read pulse |
| thr_range_evt | input | 12 | Per-channel out-of-range comparison pulse |
| thr_cross_evt | input | 12 | Per-channel threshold-crossing comparison pulse |
| seq_mode | input | 2 | Per-sequence flag mode: 0 data-present, 1 end-of-sequence |
| seq_conv_done | input | 2 | Per-sequence conversion-complete pulse |
| seq_end | input | 2 | Per-sequence whole-sequence-complete pulse |
| seq_gdat_rd | input | 2 | Per-sequence global-data read pulse |
| irq_seq_a | output | 1 | Sequence A interrupt / DMA request |
| irq_seq_b | output | 1 | Sequence B interrupt / DMA request |
| irq_thr | output | 1 | Threshold interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
Threshold flags are driven with both event kinds, once with the kind enabled and once with it disabled. Clears are written as zeros, as single ones, and in the same cycle as a new event, which shows whether enable gating, clear masking and set priority are right. Overruns are produced by back-to-back conversions on one channel, on two channels and on each sequence, and are then drained one at a time. This shows that the summary bit waits for its last contributor and follows the mode rule for sequence overruns. The two sequences run in opposite modes, and the same pulses (conversion, end, read, write of 1) are applied to each, so that data-present and latched behaviour are each confirmed and told apart.

// File: rtl/adc_flag_pkg.sv
// Package: shared constants for the ADC interrupt flag controller.
// Fixes the channel and sequence counts and the bit positions of the
// flags word and the enable word that software decodes.
package adc_flag_pkg;

    localparam int unsigned CH_NUM   = 12;
    localparam int unsigned SEQ_NUM  = 2;
    localparam int unsigned BUS_W    = 32;

    // flags word layout
    localparam int unsigned POS_THR    = 0;
    localparam int unsigned POS_CHOVR  = POS_THR + CH_NUM;
    localparam int unsigned POS_SEQOVR = 24;
    localparam int unsigned POS_SEQINT = 28;
    localparam int unsigned POS_THRINT = 30;
    localparam int unsigned POS_OVRINT = 31;

    // enable word layout
    localparam int unsigned EN_SEQ   = 0;
    localparam int unsigned EN_OVR   = EN_SEQ + SEQ_NUM;
    localparam int unsigned EN_THR   = EN_OVR + 1;
    localparam int unsigned EN_RANGE = EN_THR + 1;
    localparam int unsigned EN_CROSS = EN_RANGE + CH_NUM;
    localparam int unsigned EN_USED  = EN_CROSS + CH_NUM;

    typedef enum logic {
        SEL_FLAGS  = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/adc_chan_flags.sv
// Module: adc_chan_flags
// Holds per-channel state: a result-valid bit, an overrun bit and a
// threshold event flag, one set per channel built with generate.
// Assumes all inputs are single-cycle pulses synchronous to clk.
// A set event always beats a clear that arrives in the same cycle.
module adc_chan_flags #(
    parameter int unsigned N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] conv_done,
    input  logic [N-1:0] data_rd,
    input  logic [N-1:0] range_evt,
    input  logic [N-1:0] cross_evt,
    input  logic [N-1:0] range_en,
    input  logic [N-1:0] cross_en,
    input  logic [N-1:0] thr_clr,
    output logic [N-1:0] thr_flag,
    output logic [N-1:0] ovr_flag
);

    for (genvar c = 0; c < N; c++) begin : g_ch
        logic valid_q;
        logic ovr_q;
        logic thr_q;
        logic thr_set;

        assign thr_set = (range_evt[c] & range_en[c]) | (cross_evt[c] & cross_en[c]);

        // Track whether the channel result is still unread.
        always_ff @(posedge clk) begin
            if (!rst_n)            valid_q <= 1'b0;
            else if (conv_done[c]) valid_q <= 1'b1;
            else if (data_rd[c])   valid_q <= 1'b0;
        end

        // Latch an overrun when new data overwrites an unread result.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    ovr_q <= 1'b0;
            else if (conv_done[c] && valid_q && !data_rd[c]) ovr_q <= 1'b1;
            else if (data_rd[c])                           ovr_q <= 1'b0;
        end

        // Threshold flag: enabled events set, write-one clears, set wins.
        always_ff @(posedge clk) begin
            if (!rst_n)          thr_q <= 1'b0;
            else if (thr_set)    thr_q <= 1'b1;
            else if (thr_clr[c]) thr_q <= 1'b0;
        end

        assign thr_flag[c] = thr_q;
        assign ovr_flag[c] = ovr_q;

        AST_THR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_set && thr_clr[c]) |=> thr_flag[c]); // R3
        AST_THR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (!thr_flag[c] && !(range_evt[c] && range_en[c]) && !(cross_evt[c] && cross_en[c]))
            |=> !thr_flag[c]); // R2
        AST_CH_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (data_rd[c] && !conv_done[c]) |=> !ovr_flag[c]); // R5
    end

endmodule

// File: rtl/adc_seq_flags.sv
// Module: adc_seq_flags
// Status of one conversion sequence: global data-present, global
// overrun and the latched end-of-sequence flag. The visible sequence
// flag is selected by the mode input. Assumes pulse inputs and that
// int_clr is already qualified by the write decode and the mode.
module adc_seq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic conv_done,
    input  logic seq_end,
    input  logic gdat_rd,
    input  logic int_clr,
    output logic int_flag,
    output logic ovr_flag,
    output logic ovr_contrib
);

    logic dv_q;
    logic gov_q;
    logic done_q;

    // Global data present: set per conversion, consumed by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)         dv_q <= 1'b0;
        else if (conv_done) dv_q <= 1'b1;
        else if (gdat_rd)   dv_q <= 1'b0;
    end

    // Global overrun: conversion while previous data is unread.
    always_ff @(posedge clk) begin
        if (!rst_n)                              gov_q <= 1'b0;
        else if (conv_done && dv_q && !gdat_rd)  gov_q <= 1'b1;
        else if (gdat_rd)                        gov_q <= 1'b0;
    end

    // Latched end-of-sequence flag, active only in mode 1; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)               done_q <= 1'b0;
        else if (seq_end && mode) done_q <= 1'b1;
        else if (int_clr)         done_q <= 1'b0;
    end

    assign int_flag    = mode ? done_q : dv_q;
    assign ovr_flag    = gov_q;
    assign ovr_contrib = gov_q & ~mode;

    AST_SEQ_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !int_clr) |=> done_q); // R7
    AST_SEQ_MIRROR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && gdat_rd && !conv_done) |=> (!int_flag || mode)); // R6
    AST_SEQ_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (gdat_rd && !conv_done) |=> !ovr_flag); // R8

endmodule

// File: rtl/adc_irq_flags.sv
// Module: adc_irq_flags (top)
// Collects channel and sequence status into the flags word, holds the
// enable word, decodes bus writes (write-one-to-clear on flags, plain
// write on enables) and drives the four gated interrupt outputs.
// Assumes a single-cycle bus with combinational read data.
module adc_irq_flags
    import adc_flag_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [CH_NUM-1:0]   ch_conv_done,
    input  logic [CH_NUM-1:0]   ch_data_rd,
    input  logic [CH_NUM-1:0]   thr_range_evt,
    input  logic [CH_NUM-1:0]   thr_cross_evt,
    input  logic [SEQ_NUM-1:0]  seq_mode,
    input  logic [SEQ_NUM-1:0]  seq_conv_done,
    input  logic [SEQ_NUM-1:0]  seq_end,
    input  logic [SEQ_NUM-1:0]  seq_gdat_rd,
    output logic                irq_seq_a,
    output logic                irq_seq_b,
    output logic                irq_thr,
    output logic                irq_ovr
);

    logic                flags_wr;
    logic                en_wr;
    logic [EN_USED-1:0]  en_q;
    logic [CH_NUM-1:0]   thr_flag;
    logic [CH_NUM-1:0]   ch_ovr;
    logic [CH_NUM-1:0]   thr_clr;
    logic [SEQ_NUM-1:0]  seq_int;
    logic [SEQ_NUM-1:0]  seq_ovr;
    logic [SEQ_NUM-1:0]  seq_ovr_contrib;
    logic [SEQ_NUM-1:0]  seq_clr;
    logic                thr_int;
    logic                ovr_int;
    logic [BUS_W-1:0]    flags;
    logic [1:0]          unused_wdata;

    assign flags_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_FLAGS);
    assign en_wr    = bus_wr && (reg_sel_e'(bus_addr) == SEL_ENABLE);
    assign thr_clr  = flags_wr ? bus_wdata[POS_THR +: CH_NUM] : '0;
    assign unused_wdata = bus_wdata[BUS_W-1 -: 2];

    // Enable word: plain write of the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= bus_wdata[EN_USED-1:0];
    end

    adc_chan_flags #(
        .N (CH_NUM)
    ) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (ch_conv_done),
        .data_rd   (ch_data_rd),
        .range_evt (thr_range_evt),
        .cross_evt (thr_cross_evt),
        .range_en  (en_q[EN_RANGE +: CH_NUM]),
        .cross_en  (en_q[EN_CROSS +: CH_NUM]),
        .thr_clr   (thr_clr),
        .thr_flag  (thr_flag),
        .ovr_flag  (ch_ovr)
    );

    for (genvar s = 0; s < SEQ_NUM; s++) begin : g_seq
        // Write-one clear reaches the latch only in end-of-sequence mode.
        assign seq_clr[s] = flags_wr & bus_wdata[POS_SEQINT + s] & seq_mode[s];

        adc_seq_flags u_seq (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode        (seq_mode[s]),
            .conv_done   (seq_conv_done[s]),
            .seq_end     (seq_end[s]),
            .gdat_rd     (seq_gdat_rd[s]),
            .int_clr     (seq_clr[s]),
            .int_flag    (seq_int[s]),
            .ovr_flag    (seq_ovr[s]),
            .ovr_contrib (seq_ovr_contrib[s])
        );
    end

    assign thr_int = |thr_flag;
    assign ovr_int = (|ch_ovr) | (|seq_ovr_contrib);

    // Assemble the flags word; unused positions stay zero.
    always_comb begin
        flags = '0;
        flags[POS_THR   +: CH_NUM]  = thr_flag;
        flags[POS_CHOVR +: CH_NUM]  = ch_ovr;
        flags[POS_SEQOVR +: SEQ_NUM] = seq_ovr;
        flags[POS_SEQINT +: SEQ_NUM] = seq_int;
        flags[POS_THRINT] = thr_int;
        flags[POS_OVRINT] = ovr_int;
    end

    // Read mux for the two bus words.
    always_comb begin
        if (reg_sel_e'(bus_addr) == SEL_FLAGS) bus_rdata = flags;
        else bus_rdata = {{(BUS_W-EN_USED){1'b0}}, en_q};
    end

    // Interrupt outputs gated by the enable word.
    assign irq_seq_a = seq_int[0] & en_q[EN_SEQ];
    assign irq_seq_b = seq_int[1] & en_q[EN_SEQ + 1];
    assign irq_thr   = thr_int & en_q[EN_THR];
    assign irq_ovr   = ovr_int & en_q[EN_OVR];

    AST_THR_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_int && thr_clr == '0) |=> thr_int); // R4
    AST_OVR_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ch_ovr) && ch_data_rd == '0) |=> ovr_int); // R9
    AST_OVR_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !bus_wdata[EN_OVR]) |=> !irq_ovr); // R10
    AST_THR_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !bus_wdata[EN_THR]) |=> !irq_thr); // R10
    AST_EN_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_e'(bus_addr) == SEL_ENABLE) |-> (bus_rdata[BUS_W-1:EN_USED] == '0)); // R11

endmodule

// File: tb/test_adc_irq_flags.sv
`timescale 1ns/1ps
module test_adc_irq_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] ch_conv_done = '0;
    logic [11:0] ch_data_rd = '0;
    logic [11:0] thr_range_evt = '0;
    logic [11:0] thr_cross_evt = '0;
    logic [1:0]  seq_mode = '0;
    logic [1:0]  seq_conv_done = '0;
    logic [1:0]  seq_end = '0;
    logic [1:0]  seq_gdat_rd = '0;
    logic        irq_seq_a, irq_seq_b, irq_thr, irq_ovr;

    int total = 0;
    int bad = 0;
    logic [31:0] en_shadow = '0;

    always #2.5 clk = ~clk;

    adc_irq_flags i_adc_irq_flags (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_conv_done(ch_conv_done), .ch_data_rd(ch_data_rd),
        .thr_range_evt(thr_range_evt), .thr_cross_evt(thr_cross_evt),
        .seq_mode(seq_mode), .seq_conv_done(seq_conv_done), .seq_end(seq_end),
        .seq_gdat_rd(seq_gdat_rd), .irq_seq_a(irq_seq_a), .irq_seq_b(irq_seq_b),
        .irq_thr(irq_thr), .irq_ovr(irq_ovr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: inputs set before this call are captured at the next edge.
    task automatic step();
        @(negedge clk);
        ch_conv_done = '0; ch_data_rd = '0; thr_range_evt = '0; thr_cross_evt = '0;
        seq_conv_done = '0; seq_end = '0; seq_gdat_rd = '0; bus_wr = 1'b0;
    endtask

    task automatic read_word(input logic addr, output logic [31:0] data);
        bus_addr = addr;
        #1;
        data = bus_rdata;
    endtask

    task automatic check_flags(input string tag, input logic [31:0] exp);
        logic [31:0] d;
        read_word(1'b0, d);
        check(tag, d, exp);
    endtask

    task automatic write_flags(input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = d;
        step();
    endtask

    task automatic write_en(input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = d;
        en_shadow = d;
        step();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check_flags("R1 flags after reset", 32'h0);
        read_word(1'b1, d);
        check("R1 enable after reset", d, 32'h0);
        check("R1 irq outputs after reset", {28'h0, irq_seq_a, irq_seq_b, irq_thr, irq_ovr}, 32'h0);
    endtask

    task automatic t_threshold();
        write_en(32'h0000_0088);                 // range en ch3 (bit 7), thr irq en (bit 3)
        thr_range_evt[3] = 1'b1; thr_cross_evt[5] = 1'b1;
        step();
        check_flags("R2 enabled range sets, disabled cross ignored", 32'h4000_0008);
        check("R10 irq_thr enabled", {31'h0, irq_thr}, 32'h1);
        write_flags(32'h0);
        check_flags("R3 zero write keeps flags", 32'h4000_0008);
        write_en(32'h0020_0088);                 // add cross en ch5 (bit 21)
        thr_cross_evt[5] = 1'b1;
        step();
        check_flags("R2 enabled cross sets", 32'h4000_0028);
        write_flags(32'h0000_0008);
        check_flags("R4 summary held by remaining flag", 32'h4000_0020);
        thr_range_evt[3] = 1'b1;
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h0000_0028;
        step();
        check_flags("R3 set wins over same-cycle clear", 32'h4000_0008);
        write_flags(32'h0000_0008);
        check_flags("R4 summary drops when all clear", 32'h0);
        check("R4 irq_thr low", {31'h0, irq_thr}, 32'h0);
        write_en(32'h0020_0080);                 // thr irq en off
        thr_range_evt[3] = 1'b1;
        step();
        check("R10 irq_thr gated off", {31'h0, irq_thr}, 32'h0);
        write_flags(32'h0000_0008);
    endtask

    task automatic t_chan_overrun();
        write_en(32'h0);
        ch_conv_done[2] = 1'b1;
        step();
        check_flags("R5 single conversion no overrun", 32'h0);
        ch_conv_done[2] = 1'b1;
        step();
        check_flags("R5 unread overwrite sets overrun", 32'h8000_4000);
        check("R10 irq_ovr gated off", {31'h0, irq_ovr}, 32'h0);
        write_en(32'h0000_0004);
        check("R10 irq_ovr enabled", {31'h0, irq_ovr}, 32'h1);
        ch_conv_done[7] = 1'b1;
        step();
        ch_conv_done[7] = 1'b1;
        step();
        check_flags("R5 second channel overrun", 32'h8008_4000);
        ch_data_rd[2] = 1'b1;
        step();
        check_flags("R9 summary held by channel 7", 32'h8008_0000);
        write_flags(32'hFFFF_FFFF);
        check_flags("R11 write to read-only overrun ignored", 32'h8008_0000);
        ch_data_rd[7] = 1'b1;
        step();
        check_flags("R9 summary drops after last read", 32'h0);
        check("R9 irq_ovr low", {31'h0, irq_ovr}, 32'h0);
        ch_conv_done[4] = 1'b1;
        step();
        ch_conv_done[4] = 1'b1; ch_data_rd[4] = 1'b1;
        step();
        check_flags("R5 conversion with same-cycle read no overrun", 32'h0);
        ch_data_rd[4] = 1'b1;
        step();
    endtask

    task automatic t_seq_mode0();
        seq_mode = 2'b00;
        write_en(32'h0000_0005);
        seq_end[0] = 1'b1;
        step();
        check_flags("R7 seq_end ignored in mode 0", 32'h0);
        seq_conv_done[0] = 1'b1;
        step();
        check_flags("R6 conversion sets data-present flag", 32'h1000_0000);
        check("R10 irq_seq_a enabled", {31'h0, irq_seq_a}, 32'h1);
        write_flags(32'h1000_0000);
        check_flags("R6 write one ignored in mode 0", 32'h1000_0000);
        seq_conv_done[0] = 1'b1;
        step();
        check_flags("R8 R9 sequence overrun counts in mode 0", 32'h9100_0000);
        seq_gdat_rd[0] = 1'b1;
        step();
        check_flags("R6 R8 global read clears", 32'h0);
        check("R6 irq_seq_a low", {31'h0, irq_seq_a}, 32'h0);
    endtask

    task automatic t_seq_mode1();
        seq_mode = 2'b10;
        write_en(32'h0000_0004);
        seq_end[1] = 1'b1;
        step();
        check_flags("R7 end of sequence latches", 32'h2000_0000);
        check("R10 irq_seq_b gated off", {31'h0, irq_seq_b}, 32'h0);
        write_en(32'h0000_0006);
        check("R10 irq_seq_b enabled", {31'h0, irq_seq_b}, 32'h1);
        seq_conv_done[1] = 1'b1;
        step();
        seq_conv_done[1] = 1'b1;
        step();
        check_flags("R9 mode 1 overrun kept out of summary", 32'h2200_0000);
        seq_gdat_rd[1] = 1'b1;
        step();
        check_flags("R7 R8 read clears overrun, latch stays", 32'h2000_0000);
        seq_end[1] = 1'b1;
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h2000_0000;
        step();
        check_flags("R7 set wins over same-cycle clear", 32'h2000_0000);
        write_flags(32'h2000_0000);
        check_flags("R7 write one clears latch", 32'h0);
        seq_conv_done[1] = 1'b1;
        step();
        check_flags("R7 conversion does not set latch", 32'h0);
        seq_gdat_rd[1] = 1'b1;
        step();
        seq_mode = 2'b00;
    endtask

    task automatic t_enable_word();
        logic [31:0] d;
        write_en(32'hFFFF_FFFF);
        read_word(1'b1, d);
        check("R11 enable unused bits read zero", d, 32'h0FFF_FFFF);
        check_flags("R11 idle flags read zero", 32'h0);
        write_en(32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_chan_overrun();
        t_seq_mode0();
        t_seq_mode1();
        t_enable_word();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule